// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block is the control-flow stage of a 32-bit core that executes one instruction after every branch or jump before the transfer takes effect. It keeps two program counters: the address of the instruction now executing (`pc_q`) and the address of the one in the delay slot (`npc_q`). From the decoded fields of the current instruction and its two register operands, it works out the address that follows the delay slot. It also reports whether control is transferred and, for the linking forms, which register receives the return address and what that address is.

The unit evaluates combinationally on every cycle. The two counters move only when the `step` strobe is high. On a step, the delay-slot address becomes the current address, and the computed follow-on address becomes the new delay-slot address. A load strobe places an arbitrary address into the current PC and sets the delay-slot PC four bytes beyond it; a load overrides a step in the same cycle. `step` and `load_en` are plain control pins with no handshake. The instruction fields and operands have to be valid whenever `step` is high. The block never back-pressures, so an update completes in the cycle it is requested.

Instruction fetch, the register file, hazard handling and exceptions belong to the neighbouring blocks. The link outputs are meant to drive one write port of the register file.

Top module: `bru_flow_top`

## Requirements
- R1: While `rst_n` is low and after it rises, `pc_q` equals RESET_PC (default 0) and `npc_q` equals RESET_PC+4.
- R2: When `load_en` is high at a clock edge, `pc_q` becomes `load_pc` and `npc_q` becomes `load_pc`+4, whether or not `step` is high; a link write is not issued in that cycle.
- R3: When `step` is high and `load_en` is low at an edge, `pc_q` takes the old `npc_q` and `npc_q` takes `tgt_next`. When both strobes are low, both counters hold.
- R4: Opcode 4 is taken when `rs_val` equals `rt_val`; opcode 5 is taken when they differ.
- R5: Opcode 6 is taken when `rs_val`, read as signed, is at most zero. Opcode 7 is taken when it is above zero.
- R6: Opcode 1 with `rt_idx` bits 3..1 all zero is a conditional branch. If `rt_idx` bit 0 is 1 it is taken on signed `rs_val` >= 0, and if bit 0 is 0 it is taken on `rs_val` < 0. Any other `rt_idx` under opcode 1 is not a control transfer.
- R7: A taken conditional branch gives `tgt_next` = `npc_q` + (`imm_sext` << 2). Any instruction that is not taken gives `tgt_next` = `npc_q` + 4 and `taken` = 0.
- R8: Opcodes 2 and 3 are always taken, with `tgt_next` = {`npc_q`[31:28], `jidx`, 2'b00}. The upper four bits come from the delay-slot PC, not from `pc_q`.
- R9: Opcode 0 with function 8 or 9 is always taken, with `tgt_next` = `rs_val`. Opcode 0 with any other function is not a control transfer.
- R10: Opcode 3 links to register 31. Opcode 0 with function 9 links to `rd_idx`. Opcode 1 with `rt_idx` bit 4 set (and bits 3..1 clear) links to register 31 whether the branch is taken or not. `link_val` is `pc_q`+8, and `link_we` is high only while `step` is high and `load_en` is low.
- R11: A link whose destination index is 0 does not assert `link_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Execute the presented instruction and advance the counters |
| load_en | input | 1 | Load `load_pc` into the counters (has priority over `step`) |
| load_pc | input | 32 | Address to load |
| opcode | input | 6 | Primary opcode of the current instruction |
| rt_idx | input | 5 | rt field (condition select under opcode 1) |
| rd_idx | input | 5 | rd field (link destination for function 9) |
| funct | input | 6 | Function field under opcode 0 |
| imm_sext | input | 32 | Sign-extended 16-bit immediate |
| jidx | input | 26 | Jump index field |
| rs_val | input | 32 | Value of register rs |
| rt_val | input | 32 | Value of register rt |
| pc_q | output | 32 | Address of the executing instruction |
| npc_q | output | 32 | Address of the delay-slot instruction |
| tgt_next | output | 32 | Address after the delay slot |
| taken | output | 1 | Control transfer taken |
| link_we | output | 1 | Link write enable |
| link_idx | output | 5 | Link destination register |
| link_val | output | 32 | Return address (`pc_q`+8) |

## Verification
The hardest case to reach from the ports is an index jump whose delay slot lies in a different 256 MB region than the jump itself. That is the only case where the region bits from `npc_q` and from `pc_q` disagree. The bench reaches it by loading PCs just below a region boundary (such as 0x2FFFFFFC) before each jump. Signed edge operands (0, 1, -1, the most positive value and the most negative value) are swept against every conditional opcode. The linking branch forms are stepped both taken and untaken to show that the link write does not depend on the outcome.

// File: rtl/bru_flow_pkg.sv
package bru_flow_pkg;

  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_REGIMM  = 6'd1;
  localparam logic [5:0] OP_J       = 6'd2;
  localparam logic [5:0] OP_JAL     = 6'd3;
  localparam logic [5:0] OP_BEQ     = 6'd4;
  localparam logic [5:0] OP_BNE     = 6'd5;
  localparam logic [5:0] OP_BLEZ    = 6'd6;
  localparam logic [5:0] OP_BGTZ    = 6'd7;
  localparam logic [5:0] FN_JR      = 6'd8;
  localparam logic [5:0] FN_JALR    = 6'd9;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_COND = 2'd1,
    KIND_JIDX = 2'd2,
    KIND_JREG = 2'd3
  } flow_kind_e;

  typedef struct packed {
    flow_kind_e kind;
    logic       link;     // instruction writes a return address
    logic       link_rd;  // destination is rd instead of the fixed link register
  } flow_dec_t;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
  import bru_flow_pkg::*;
#(
  parameter int RIDX = 5
) (
  input  logic [5:0]      opcode,
  input  logic [RIDX-1:0] rt_idx,
  input  logic [5:0]      funct,
  output flow_dec_t       dec
);

  logic regimm_ok;
  assign regimm_ok = (rt_idx[3:1] == 3'b000);

  always_comb begin
    dec.kind    = KIND_NONE;
    dec.link    = 1'b0;
    dec.link_rd = 1'b0;
    case (opcode)
      OP_SPECIAL: begin
        if (funct == FN_JR) begin
          dec.kind = KIND_JREG;
        end else if (funct == FN_JALR) begin
          dec.kind    = KIND_JREG;
          dec.link    = 1'b1;
          dec.link_rd = 1'b1;
        end
      end
      OP_REGIMM: begin
        if (regimm_ok) begin
          dec.kind = KIND_COND;
          dec.link = rt_idx[4];
        end
      end
      OP_J:   dec.kind = KIND_JIDX;
      OP_JAL: begin
        dec.kind = KIND_JIDX;
        dec.link = 1'b1;
      end
      OP_BEQ, OP_BNE, OP_BLEZ, OP_BGTZ: dec.kind = KIND_COND;
      default: dec.kind = KIND_NONE;
    endcase
  end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
  import bru_flow_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [5:0]      opcode,
  input  logic            sel_ge,   // rt bit 0 under the branch group
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic            cond_ok
);

  logic [XLEN-1:0] diff_bits;
  logic            ops_equal;
  logic            rs_neg;
  logic            rs_zero;

  // per-bit difference, reduced below
  genvar b;
  generate
    for (b = 0; b < XLEN; b++) begin : g_diff
      assign diff_bits[b] = rs_val[b] ^ rt_val[b];
    end
  endgenerate

  assign ops_equal = ~|diff_bits;
  assign rs_neg    = rs_val[XLEN-1];
  assign rs_zero   = ~|rs_val;

  always_comb begin
    case (opcode)
      OP_BEQ:    cond_ok = ops_equal;
      OP_BNE:    cond_ok = ~ops_equal;
      OP_BLEZ:   cond_ok = rs_neg | rs_zero;
      OP_BGTZ:   cond_ok = ~rs_neg & ~rs_zero;
      OP_REGIMM: cond_ok = sel_ge ? ~rs_neg : rs_neg;
      default:   cond_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/bru_target.sv
module bru_target
  import bru_flow_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int JIDX_W = 26
) (
  input  flow_kind_e        kind,
  input  logic              taken,
  input  logic [XLEN-1:0]   npc,
  input  logic [XLEN-1:0]   imm_sext,
  input  logic [JIDX_W-1:0] jidx,
  input  logic [XLEN-1:0]   rs_val,
  output logic [XLEN-1:0]   tgt
);

  localparam int REG_W = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] seq_tgt;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] ji_tgt;

  assign seq_tgt = npc + XLEN'(4);
  assign br_tgt  = npc + {imm_sext[XLEN-3:0], 2'b00};

  generate
    if (REG_W > 0) begin : g_region
      assign ji_tgt = {npc[XLEN-1 -: REG_W], jidx, 2'b00};
    end else begin : g_flat
      assign ji_tgt = XLEN'({jidx, 2'b00});
    end
  endgenerate

  always_comb begin
    tgt = seq_tgt;
    if (taken) begin
      case (kind)
        KIND_COND: tgt = br_tgt;
        KIND_JIDX: tgt = ji_tgt;
        KIND_JREG: tgt = rs_val;
        default:   tgt = seq_tgt;
      endcase
    end
  end

endmodule

// File: rtl/bru_pc_reg.sv
module bru_pc_reg #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            load_en,
  input  logic [XLEN-1:0] load_pc,
  input  logic [XLEN-1:0] tgt,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] npc_q
);

  localparam logic [XLEN-1:0] RST_A = XLEN'(RESET_PC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RST_A;
      npc_q <= RST_A + XLEN'(4);
    end else if (load_en) begin
      pc_q  <= load_pc;
      npc_q <= load_pc + XLEN'(4);
    end else if (step) begin
      pc_q  <= npc_q;
      npc_q <= tgt;
    end
  end

endmodule

// File: rtl/bru_flow_top.sv
module bru_flow_top
  import bru_flow_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          RIDX     = 5,
  parameter int          JIDX_W   = 26,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load_en,
  input  logic [XLEN-1:0]   load_pc,
  input  logic [5:0]        opcode,
  input  logic [RIDX-1:0]   rt_idx,
  input  logic [RIDX-1:0]   rd_idx,
  input  logic [5:0]        funct,
  input  logic [XLEN-1:0]   imm_sext,
  input  logic [JIDX_W-1:0] jidx,
  input  logic [XLEN-1:0]   rs_val,
  input  logic [XLEN-1:0]   rt_val,
  output logic [XLEN-1:0]   pc_q,
  output logic [XLEN-1:0]   npc_q,
  output logic [XLEN-1:0]   tgt_next,
  output logic              taken,
  output logic              link_we,
  output logic [RIDX-1:0]   link_idx,
  output logic [XLEN-1:0]   link_val
);

  localparam logic [RIDX-1:0] LINK_REG = {RIDX{1'b1}};

  flow_dec_t dec;
  logic      cond_ok;
  logic      commit;

  bru_decode #(.RIDX(RIDX)) u_dec (
    .opcode (opcode),
    .rt_idx (rt_idx),
    .funct  (funct),
    .dec    (dec)
  );

  bru_cond #(.XLEN(XLEN)) u_cond (
    .opcode  (opcode),
    .sel_ge  (rt_idx[0]),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .cond_ok (cond_ok)
  );

  always_comb begin
    case (dec.kind)
      KIND_COND:            taken = cond_ok;
      KIND_JIDX, KIND_JREG: taken = 1'b1;
      default:              taken = 1'b0;
    endcase
  end

  bru_target #(.XLEN(XLEN), .JIDX_W(JIDX_W)) u_tgt (
    .kind     (dec.kind),
    .taken    (taken),
    .npc      (npc_q),
    .imm_sext (imm_sext),
    .jidx     (jidx),
    .rs_val   (rs_val),
    .tgt      (tgt_next)
  );

  bru_pc_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .load_en (load_en),
    .load_pc (load_pc),
    .tgt     (tgt_next),
    .pc_q    (pc_q),
    .npc_q   (npc_q)
  );

  assign commit   = step & ~load_en;
  assign link_idx = dec.link_rd ? rd_idx : LINK_REG;
  assign link_val = pc_q + XLEN'(8);
  assign link_we  = commit & dec.link & (|link_idx);

endmodule

// File: rtl/bru_flow_chk.sv
module bru_flow_chk #(
  parameter int XLEN   = 32,
  parameter int RIDX   = 5,
  parameter int JIDX_W = 26
) (
  input logic            clk,
  input logic            rst_n,
  input logic            step,
  input logic            load_en,
  input logic [XLEN-1:0] load_pc,
  input logic [5:0]      opcode,
  input logic [5:0]      funct,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] npc_q,
  input logic            taken,
  input logic            link_we,
  input logic [RIDX-1:0] link_idx
);

  localparam int REG_W = XLEN - JIDX_W - 2;

  assert_load_sets_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (pc_q == $past(load_pc)) && (npc_q == pc_q + XLEN'(4)));

  assert_step_shifts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en) |=> pc_q == $past(npc_q));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_en) |=> $stable(pc_q) && $stable(npc_q));

  assert_untaken_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && !taken) |=> npc_q == $past(npc_q) + XLEN'(4));

  assert_jump_always_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 6'd2 || opcode == 6'd3) |-> taken);

  assert_region_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && (opcode == 6'd2 || opcode == 6'd3))
    |=> npc_q[XLEN-1 -: REG_W] == pc_q[XLEN-1 -: REG_W]);

  assert_reg_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && opcode == 6'd0 && (funct == 6'd8 || funct == 6'd9))
    |=> npc_q == $past(rs_val));

  assert_link_on_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (step && !load_en));

  assert_no_zero_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_idx != '0));

endmodule

bind bru_flow_top bru_flow_chk #(.XLEN(XLEN), .RIDX(RIDX), .JIDX_W(JIDX_W)) u_flow_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step     (step),
  .load_en  (load_en),
  .load_pc  (load_pc),
  .opcode   (opcode),
  .funct    (funct),
  .rs_val   (rs_val),
  .pc_q     (pc_q),
  .npc_q    (npc_q),
  .taken    (taken),
  .link_we  (link_we),
  .link_idx (link_idx)
);

// File: tb/tb_bru_flow_top.sv
`timescale 1ns/1ps
module tb_bru_flow_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic        load_en = 1'b0;
  logic [31:0] load_pc = '0;
  logic [5:0]  opcode = '0;
  logic [4:0]  rt_idx = '0;
  logic [4:0]  rd_idx = '0;
  logic [5:0]  funct = '0;
  logic [31:0] imm_sext = '0;
  logic [25:0] jidx = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [31:0] pc_q, npc_q, tgt_next, link_val;
  logic        taken, link_we;
  logic [4:0]  link_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bru_flow_top dut (
    .clk(clk), .rst_n(rst_n), .step(step), .load_en(load_en), .load_pc(load_pc),
    .opcode(opcode), .rt_idx(rt_idx), .rd_idx(rd_idx), .funct(funct),
    .imm_sext(imm_sext), .jidx(jidx), .rs_val(rs_val), .rt_val(rt_val),
    .pc_q(pc_q), .npc_q(npc_q), .tgt_next(tgt_next), .taken(taken),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  // expected behaviour, written from the requirement list
  task automatic model(input logic [31:0] pcv, input logic [5:0] op,
                       input logic [4:0] rt, input logic [4:0] rd,
                       input logic [5:0] fn, input logic [31:0] imm,
                       input logic [25:0] ji, input logic [31:0] a,
                       input logic [31:0] b,
                       output bit tk, output logic [31:0] nn,
                       output bit lw, output logic [4:0] li);
    logic [31:0] npcv;
    bit cond, is_cond, lk;
    npcv = pcv + 32'd4;
    tk = 0; is_cond = 0; lk = 0; li = 5'd31; cond = 0;
    nn = npcv + 32'd4;
    if (op == 6'd0 && (fn == 6'd8 || fn == 6'd9)) begin
      tk = 1; nn = a;
      if (fn == 6'd9) begin lk = 1; li = rd; end
    end else if (op == 6'd1 && rt[3:1] == 3'd0) begin
      is_cond = 1;
      cond = rt[0] ? ($signed(a) >= 0) : ($signed(a) < 0);
      lk = rt[4];
    end else if (op == 6'd2 || op == 6'd3) begin
      tk = 1; nn = {npcv[31:28], ji, 2'b00};
      lk = (op == 6'd3);
    end else if (op >= 6'd4 && op <= 6'd7) begin
      is_cond = 1;
      case (op)
        6'd4: cond = (a == b);
        6'd5: cond = (a != b);
        6'd6: cond = ($signed(a) <= 0);
        default: cond = ($signed(a) > 0);
      endcase
    end
    if (is_cond && cond) begin
      tk = 1; nn = npcv + imm * 32'd4;
    end
    lw = lk && (li != 5'd0);
  endtask

  task automatic load_to(input logic [31:0] p);
    @(negedge clk);
    load_en = 1'b1; load_pc = p; step = 1'b0;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run(input string tag, input logic [31:0] pcv, input logic [5:0] op,
                     input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] fn,
                     input logic [31:0] imm, input logic [25:0] ji,
                     input logic [31:0] a, input logic [31:0] b);
    bit tk, lw;
    logic [31:0] nn;
    logic [4:0] li;
    model(pcv, op, rt, rd, fn, imm, ji, a, b, tk, nn, lw, li);
    load_to(pcv);
    opcode = op; rt_idx = rt; rd_idx = rd; funct = fn;
    imm_sext = imm; jidx = ji; rs_val = a; rt_val = b; step = 1'b1;
    #1;
    chk(tag, "taken", {31'd0, taken}, {31'd0, tk});
    chk(tk ? tag : "R7", "tgt_next", tgt_next, nn);
    chk(li == 5'd0 ? "R11" : "R10", "link_we", {31'd0, link_we}, {31'd0, lw});
    if (lw) begin
      chk("R10", "link_idx", {27'd0, link_idx}, {27'd0, li});
      chk("R10", "link_val", link_val, pcv + 32'd8);
    end
    @(negedge clk);
    step = 1'b0;
    #1;
    chk("R3", "pc after step", pc_q, pcv + 32'd4);
    chk("R3", "npc after step", npc_q, nn);
  endtask

  initial begin
    logic [31:0] vals [6];
    logic [31:0] pcs [3];
    logic [4:0]  rts [6];
    logic [25:0] jis [3];
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h5};
    pcs  = '{32'h0040_1000, 32'h2FFF_FFFC, 32'hFFFF_FFF8};
    rts  = '{5'd0, 5'd1, 5'd16, 5'd17, 5'd2, 5'd8};
    jis  = '{26'h0, 26'h3FF_FFFF, 26'h123_4567};

    // reset values
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "pc in reset", pc_q, 32'h0);
    chk("R1", "npc in reset", npc_q, 32'h4);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "pc after reset", pc_q, 32'h0);
    chk("R1", "npc after reset", npc_q, 32'h4);

    // idle hold with a linking jump presented: nothing moves, no link
    load_to(32'h0000_1000);
    opcode = 6'd3; jidx = 26'h55; step = 1'b0;
    #1;
    chk("R10", "link_we without step", {31'd0, link_we}, 32'd0);
    @(negedge clk); #1;
    chk("R3", "pc held", pc_q, 32'h0000_1000);
    chk("R3", "npc held", npc_q, 32'h0000_1004);

    // load wins over step
    @(negedge clk);
    load_en = 1'b1; load_pc = 32'h0123_4560; step = 1'b1;
    #1;
    chk("R2", "no link during load", {31'd0, link_we}, 32'd0);
    @(negedge clk);
    load_en = 1'b0; step = 1'b0;
    #1;
    chk("R2", "pc after load", pc_q, 32'h0123_4560);
    chk("R2", "npc after load", npc_q, 32'h0123_4564);

    // equality branches
    for (int op = 4; op <= 5; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          for (int p = 0; p < 2; p++)
            run("R4", pcs[p], 6'(op), 5'd3, 5'd0, 6'd0,
                ((i + j) % 2 == 1) ? 32'd4 : 32'hFFFF_FFFD, 26'd0, vals[i], vals[j]);

    // sign-test branches
    for (int op = 6; op <= 7; op++)
      for (int i = 0; i < 6; i++)
        for (int p = 0; p < 2; p++)
          run("R5", pcs[p], 6'(op), 5'd0, 5'd0, 6'd0, 32'h0000_0100, 26'd0, vals[i], 32'h0);

    // branch group selected by rt, including linking forms and non-branch rt
    for (int r = 0; r < 6; r++)
      for (int i = 0; i < 6; i++)
        for (int p = 0; p < 2; p++)
          run("R6", pcs[p], 6'd1, rts[r], 5'd0, 6'd0, 32'hFFFF_FF00, 26'd0, vals[i], 32'h0);

    // index jumps across region boundaries
    for (int op = 2; op <= 3; op++)
      for (int k = 0; k < 3; k++)
        for (int p = 0; p < 3; p++)
          run("R8", pcs[p], 6'(op), 5'd0, 5'd0, 6'd0, 32'h0, jis[k], 32'h0, 32'h0);

    // register jumps, link into rd including index 0, and a non-jump function
    for (int f = 0; f < 3; f++)
      for (int d = 0; d < 3; d++)
        for (int i = 0; i < 6; i++)
          run((d == 0) ? "R11" : "R9", pcs[i % 3],
              6'd0, 5'd0, (d == 0) ? 5'd0 : ((d == 1) ? 5'd7 : 5'd31),
              (f == 0) ? 6'd8 : ((f == 1) ? 6'd9 : 6'd32),
              32'h0, 26'd0, vals[i] & 32'hFFFF_FFFC, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule